// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master DMA Arbiter

This block chooses which of two IDE bus-master DMA channels, primary and secondary, moves the next 16-bit word to or from memory. It also decides when the system bus has to be handed back. Its claim on the bus ranks below the CPU and the legacy DMA controller. Before any word moves, the block raises a hold request and waits for the grant. It then spends one settle cycle before the first word. Each word lasts a programmable number of clock cycles, which models the memory cycle time.

Each channel has three controls:
- a device DMA request;
- a start bit, without which its request is ignored;
- a mode bit that selects block (multiword) or single-word transfers.

A sticky alternating-priority flip-flop keeps the two channels fair. After each bus release the channel that did not just own the bus is preferred. The block also keeps a remaining byte count for each channel's current descriptor. It pulses an end-of-descriptor strobe on the word that empties that count, so that status logic elsewhere can clear the channel's active bit.

Top module: `ide_dma_arbiter`

## Requirements
- R1: After reset, holdReq, xferActive, wordDone and both descEnd bits are 0, and the priority flip-flop favours the primary channel.
- R2: A channel is eligible only while both its dmaReq bit and its startBit bit are 1. Bit 0 of every two-bit vector port is the primary channel and bit 1 is the secondary channel.
  - With no eligible channel, holdReq never rises.
  - Clearing a channel's start bit during a block releases the bus after the current word.
- R3: holdReq is 1 from the first cycle after an idle arbiter samples an eligible request. No word starts before holdAck is 1. Exactly one settle cycle follows the grant, so with a constant grant the first wordDone is seen waitCycles+3 cycles after the request is sampled.
- R4: Each word keeps xferActive high for waitCycles+1 cycles. wordDone is a one-cycle strobe in the last of those cycles.
- R5: In single-word mode the bus is released after every word: holdReq is 0 in the cycle after each wordDone.
- R6: In block mode the channel moves words back to back while it stays eligible and holdAck stays 1. It releases the bus after the word at whose end its request is found low.
- R7: When both channels are eligible at selection, the channel other than the last one to release the bus after a transfer wins. The priority flip-flop changes only when a transfer releases the bus.
- R8: While a channel holds the bus, the other channel is not served and xferChan stays fixed, even if the other channel is requesting.
- R9: If the favoured channel is not eligible, the other eligible channel is selected in the same cycle, with the same latency as in R3.
- R10: If holdAck falls during a block word, that word still completes. holdReq then stays 1 with no word in progress, and after holdAck returns the same channel continues without a priority change.
- R11: A pulse on descLoad[i] loads descBytes into channel i's byte count. Each completed word of channel i lowers that count by 2, saturating at 0. descEnd[i] pulses with the wordDone of the word that takes a non-zero count to 0. A count that is already 0 gives no pulse.
- R12: xferChan shows the channel of the word in progress: 0 for primary, 1 for secondary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaReq | input | 2 | Device DMA request for each channel |
| startBit | input | 2 | Start (enable) bit for each channel |
| blockMode | input | 2 | 1 selects block mode, 0 selects single-word mode, for each channel |
| holdAck | input | 1 | Bus grant from the higher-priority owner |
| waitCycles | input | WAIT_W | Extra clock cycles per word beyond the first |
| descLoad | input | 2 | Load strobe for each channel's descriptor byte count |
| descBytes | input | CNT_W | Byte count loaded by descLoad |
| holdReq | output | 1 | Bus hold request |
| xferActive | output | 1 | A word transfer is in progress |
| xferChan | output | 1 | Channel of the word in progress |
| wordDone | output | 1 | Last cycle of a word |
| descEnd | output | 2 | End-of-descriptor pulse for each channel |

## Verification
With a constant grant, the first word of a fresh selection ends waitCycles+3 cycles after the request is sampled. Back-to-back block words end every waitCycles+1 cycles. A single-word release drops holdReq in the cycle right after wordDone. The bench drives inputs on falling edges and counts rising edges until it sees the result it expects on the following falling edge. It compares that count with these formulas, and it checks release and withdrawal states exactly one cycle after the wordDone that causes them. A scoreboard queue fixes the order of channels and descriptor-end flags. A monitor pops the queue on every wordDone and compares the channel and the descEnd vector in that same cycle.

// File: rtl/ide_arb_pkg.sv
package ide_arb_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_XFER   = 2'd3
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wordLoad;  // start a new word: load the wait counter
    logic wordTick;  // word in progress, not in its last cycle
    logic wordDone;  // last cycle of a word
    logic chan;      // channel owning the word
  } arbStrobe_t;
endpackage

// File: rtl/ide_arb_ctrl.sv
module ide_arb_ctrl
  import ide_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dmaReq,
  input  logic [NUM_CH-1:0] startBit,
  input  logic [NUM_CH-1:0] blockMode,
  input  logic              holdAck,
  input  logic              wordLast,
  output logic              holdReq,
  output logic              xferActive,
  output logic              xferChan,
  output arbStrobe_t        strobe
);
  arbState_t   state, stateNext;
  logic        chan, chanNext;
  logic        prio, prioNext;
  logic [NUM_CH-1:0] eligible;
  logic        anyElig, pickChan, ownElig, contBlock, wordDone;

  assign eligible  = dmaReq & startBit;
  assign anyElig   = |eligible;
  // favoured channel first, otherwise the other one in the same cycle
  assign pickChan  = eligible[prio] ? prio : ~prio;
  assign ownElig   = eligible[chan];
  assign wordDone  = (state == ST_XFER) && wordLast;
  assign contBlock = blockMode[chan] && ownElig && holdAck;

  always_comb begin
    stateNext = state;
    chanNext  = chan;
    prioNext  = prio;
    unique case (state)
      ST_IDLE: begin
        if (anyElig) begin
          stateNext = ST_HOLD;
          chanNext  = pickChan;
        end
      end
      ST_HOLD: begin
        if (holdAck) stateNext = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (!holdAck)     stateNext = ST_HOLD;
        else if (ownElig) stateNext = ST_XFER;
        else              stateNext = ST_IDLE;
      end
      ST_XFER: begin
        if (wordLast) begin
          if (contBlock) begin
            stateNext = ST_XFER;
          end else if (blockMode[chan] && ownElig && !holdAck) begin
            stateNext = ST_HOLD;          // grant withdrawn: ask again
          end else begin
            stateNext = ST_IDLE;          // transfer releases the bus
            prioNext  = ~chan;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chan  <= 1'b0;
      prio  <= 1'b0;
    end else begin
      state <= stateNext;
      chan  <= chanNext;
      prio  <= prioNext;
    end
  end

  assign holdReq    = (state != ST_IDLE);
  assign xferActive = (state == ST_XFER);
  assign xferChan   = chan;

  always_comb begin
    strobe.wordLoad = ((state == ST_SETTLE) && holdAck && ownElig) ||
                      (wordDone && contBlock);
    strobe.wordTick = (state == ST_XFER) && !wordLast;
    strobe.wordDone = wordDone;
    strobe.chan     = chan;
  end

  // R2: a hold request only starts from an eligible request
  p_gate_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdReq) |-> $past(|(dmaReq & startBit)));

  // R3: a word never starts without a grant in the cycle before
  p_grant_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferActive) |-> $past(holdAck));

  // R5: single-word mode gives the bus back after every word
  p_single_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && !blockMode[xferChan]) |=> !holdReq);

  // R7: priority only moves at the end of a word
  p_prio_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wordDone |=> $stable(prio));

  // R8: the owner cannot change in the middle of a word
  p_owner_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && !wordDone) |=> (xferActive && $stable(xferChan)));

  // R10: withdrawal mid-block keeps the hold request up
  p_withdraw_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && blockMode[xferChan] && eligible[xferChan] && !holdAck)
      |=> (holdReq && !xferActive));
endmodule

// File: rtl/ide_arb_dpath.sv
module ide_arb_dpath
  import ide_arb_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [WAIT_W-1:0] waitCycles,
  input  logic [NUM_CH-1:0] descLoad,
  input  logic [CNT_W-1:0]  descBytes,
  output logic              wordLast,
  output logic [NUM_CH-1:0] descEnd
);
  localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(2);

  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                waitCnt <= '0;
    else if (strobe.wordLoad) waitCnt <= waitCycles;
    else if (strobe.wordTick) waitCnt <= waitCnt - 1'b1;
  end

  assign wordLast = (waitCnt == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_desc
    logic [CNT_W-1:0] remain;
    logic             hit;

    assign hit = strobe.wordDone && (strobe.chan == ch[0]);

    always_ff @(posedge clk) begin
      if (!rstN)             remain <= '0;
      else if (descLoad[ch]) remain <= descBytes;
      else if (hit)          remain <= (remain <= WORD_BYTES) ? '0 : remain - WORD_BYTES;
    end

    assign descEnd[ch] = hit && (remain != '0) && (remain <= WORD_BYTES);
  end

  // R11: a descriptor end only comes with a finished word, one channel at a time
  p_end_with_word_r11: assert property (@(posedge clk) disable iff (!rstN)
    (|descEnd) |-> (strobe.wordDone && $onehot0(descEnd)));

  // R4: the wait counter only counts down while a word is in progress
  p_wait_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordTick |=> (waitCnt == $past(waitCnt) - 1'b1));
endmodule

// File: rtl/ide_dma_arbiter.sv
module ide_dma_arbiter
  import ide_arb_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        dmaReq,
  input  logic [1:0]        startBit,
  input  logic [1:0]        blockMode,
  input  logic              holdAck,
  input  logic [WAIT_W-1:0] waitCycles,
  input  logic [1:0]        descLoad,
  input  logic [CNT_W-1:0]  descBytes,
  output logic              holdReq,
  output logic              xferActive,
  output logic              xferChan,
  output logic              wordDone,
  output logic [1:0]        descEnd
);
  arbStrobe_t strobe;
  logic       wordLast;

  ide_arb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dmaReq     (dmaReq),
    .startBit   (startBit),
    .blockMode  (blockMode),
    .holdAck    (holdAck),
    .wordLast   (wordLast),
    .holdReq    (holdReq),
    .xferActive (xferActive),
    .xferChan   (xferChan),
    .strobe     (strobe)
  );

  ide_arb_dpath #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .waitCycles (waitCycles),
    .descLoad   (descLoad),
    .descBytes  (descBytes),
    .wordLast   (wordLast),
    .descEnd    (descEnd)
  );

  assign wordDone = strobe.wordDone;
endmodule

// File: tb/tb_ide_dma_arbiter.sv
module tb_ide_dma_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_W = 4;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] dmaReq = '0, startBit = '0, blockMode = '0, descLoad = '0;
  logic holdAck = 1'b1;
  logic [WAIT_W-1:0] waitCycles = '0;
  logic [CNT_W-1:0] descBytes = '0;
  logic holdReq, xferActive, xferChan, wordDone;
  logic [1:0] descEnd;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic       chan;
    logic [1:0] ends;
    string      req;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_dma_arbiter #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .startBit(startBit),
    .blockMode(blockMode), .holdAck(holdAck), .waitCycles(waitCycles),
    .descLoad(descLoad), .descBytes(descBytes), .holdReq(holdReq),
    .xferActive(xferActive), .xferChan(xferChan), .wordDone(wordDone),
    .descEnd(descEnd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expectWord(input logic ch, input logic [1:0] ends, input string req);
    exp_t e;
    e.chan = ch; e.ends = ends; e.req = req;
    expQ.push_back(e);
  endtask

  // returns at the falling edge of the n-th word end
  task automatic waitWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!wordDone) @(negedge clk);
    end
  endtask

  // rising edges from the request until wordDone; also counts xferActive cycles
  task automatic latency(output int n, output int act, output bit holdEarly);
    n = 0; act = 0; holdEarly = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 1) holdEarly = holdReq;
      if (xferActive) act++;
    end while (!wordDone && n < 50);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && wordDone) begin
      if (expQ.size() == 0) begin
        check(0, "R12", "unexpected word on channel", int'(xferChan), -1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(xferChan == e.chan, e.req, "word channel (R12)", int'(xferChan), int'(e.chan));
        check(descEnd == e.ends, "R11", "descEnd vector", int'(descEnd), int'(e.ends));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, act;
    bit hold1;
    bit sawHold;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(!holdReq && !xferActive, "R1", "hold/xfer after reset", int'({holdReq, xferActive}), 0);
    check(!wordDone && descEnd == 2'b00, "R1", "strobes after reset", int'({wordDone, descEnd}), 0);

    // R2: requests without start bits are ignored
    dmaReq = 2'b11; startBit = 2'b00;
    sawHold = 0;
    repeat (8) begin
      @(negedge clk);
      if (holdReq) sawHold = 1;
    end
    check(!sawHold, "R2", "holdReq without start bit", int'(sawHold), 0);
    dmaReq = 2'b00;

    // R3 R4 R5: single word on primary, waitCycles = 2
    startBit = 2'b11; blockMode = 2'b00; waitCycles = 4'd2;
    @(negedge clk);
    expectWord(1'b0, 2'b00, "R3");
    dmaReq = 2'b01;
    latency(n, act, hold1);
    check(hold1, "R3", "holdReq one cycle after request", int'(hold1), 1);
    check(n == 5, "R3", "first word latency", n, 5);
    check(act == 3, "R4", "xferActive cycles per word", act, 3);
    dmaReq = 2'b00;
    @(negedge clk);
    check(!holdReq, "R5", "holdReq after single word", int'(holdReq), 0);
    // priority now favours secondary

    // R9: favoured secondary idle, primary served with the same latency
    repeat (2) @(negedge clk);
    expectWord(1'b0, 2'b00, "R9");
    dmaReq = 2'b01;
    latency(n, act, hold1);
    check(n == 5, "R9", "fallback latency", n, 5);
    dmaReq = 2'b00;
    repeat (3) @(negedge clk);

    // R7: alternation, single-word mode, both requesting, secondary favoured
    expectWord(1'b1, 2'b00, "R7");
    expectWord(1'b0, 2'b00, "R7");
    expectWord(1'b1, 2'b00, "R7");
    expectWord(1'b0, 2'b00, "R7");
    dmaReq = 2'b11;
    waitWords(4);
    dmaReq = 2'b00;
    repeat (3) @(negedge clk);

    // R6 R8: block mode, waitCycles = 0, secondary favoured and keeps the bus
    blockMode = 2'b11; waitCycles = 4'd0;
    expectWord(1'b1, 2'b00, "R8");
    expectWord(1'b1, 2'b00, "R8");
    expectWord(1'b1, 2'b00, "R8");
    expectWord(1'b0, 2'b00, "R6");
    expectWord(1'b0, 2'b00, "R6");
    dmaReq = 2'b11;
    waitWords(1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(wordDone, "R6", "back-to-back block word", int'(wordDone), 1);
    end
    dmaReq = 2'b01;           // secondary drops during its last word
    waitWords(2);
    dmaReq = 2'b00;
    @(negedge clk);
    check(!holdReq, "R6", "release after request low", int'(holdReq), 0);
    repeat (3) @(negedge clk);

    // R10: grant withdrawn mid-word, waitCycles = 3, secondary favoured
    waitCycles = 4'd3;
    expectWord(1'b1, 2'b00, "R10");
    expectWord(1'b1, 2'b00, "R10");
    expectWord(1'b1, 2'b00, "R10");
    expectWord(1'b0, 2'b00, "R7");
    dmaReq = 2'b11;
    waitWords(1);
    @(negedge clk);
    holdAck = 1'b0;           // in the middle of the second word
    waitWords(1);
    @(negedge clk);
    check(holdReq && !xferActive, "R10", "hold kept, no word, after withdrawal",
          int'({holdReq, xferActive}), 2);
    repeat (3) @(negedge clk);
    holdAck = 1'b1;
    waitWords(1);
    dmaReq = 2'b01;
    waitWords(1);
    dmaReq = 2'b00;
    repeat (3) @(negedge clk);

    // R11: descriptor end, 4 bytes on primary, waitCycles = 0, block mode
    waitCycles = 4'd0;
    descBytes = 16'd4; descLoad = 2'b01;
    @(negedge clk);
    descLoad = 2'b00;
    expectWord(1'b0, 2'b00, "R11");
    expectWord(1'b0, 2'b01, "R11");
    expectWord(1'b0, 2'b00, "R11");
    dmaReq = 2'b01;
    waitWords(3);
    dmaReq = 2'b00;
    repeat (3) @(negedge clk);

    // R2: start bit cleared during a block releases after the current word
    expectWord(1'b1, 2'b00, "R2");
    dmaReq = 2'b10;
    waitWords(1);
    startBit = 2'b01;
    sawHold = 0;
    @(negedge clk);
    repeat (5) begin
      if (holdReq) sawHold = 1;
      @(negedge clk);
    end
    check(!sawHold, "R2", "holdReq after start bit cleared", int'(sawHold), 0);
    dmaReq = 2'b00;
    repeat (3) @(negedge clk);

    check(expQ.size() == 0, "R12", "words left unseen in scoreboard", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule